// File: doc/BRIEF.md
# Device Start-Up Phase Sequencer

This block moves a programmable device from its configuration state into normal operation. It steps through a short run of numbered start-up phases, from 0 up to 6. Each step needs one tick from a selected advancing clock source. Three global controls change state at phases chosen in configuration: the DONE indication goes high, the global output tri-state is released, and the global write enable is granted. Once phase 6 is reached, a sticky user-mode flag rises and stays high until reset.

The sequence can be told to stall. In one mode, it will not enter the phase that releases the tri-state or grants write enable until an external DONE level reads high. Several devices that share one DONE line therefore leave start-up together. In a second mode, it holds at a chosen phase until every selected clock-manager lock input reads high. Both wait inputs are asynchronous and pass through two-flop synchronisers. User logic can force the global tri-state and the global set/reset at any time, including after start-up has finished.

All logic runs on one clock, `clk`. The three possible advancing sources arrive as single-cycle tick enables in that domain. A static select picks one of them with an enable multiplexer, so switching sources never creates a clock glitch.

Top module: `startup_seq`

## Requirements
- R1: After reset `phase` is 0. On each clock where the selected tick is high and no stall applies, `phase` rises by exactly one. It never exceeds 6 and holds at 6.
- R2: `doneOut` is high exactly when `phase` is at or above the programmed DONE phase `doneCycle`.
- R3: `gtsOut` is high while `phase` is below the programmed `gtsCycle`, and is also high whenever `userGts` is high.
- R4: `gweOut` is high exactly when `phase` is at or above the programmed `gweCycle`.
- R5: The encoding of `clkSel` picks the advancing tick: 0 selects `cfgTick`, 1 selects `userTick`, 2 selects `jtagTick`, and 3 selects `cfgTick`. Ticks on the unselected inputs have no effect on `phase`.
- R6: `gsrOut` follows `userGsr` in every phase, including after user mode is reached. `userGts` likewise forces `gtsOut` high after user mode is reached.
- R7: With `waitDoneEn` high, the step into the phase equal to `gtsCycle` or `gweCycle` is blocked while the synchronised `extDoneIn` is low. With `waitDoneEn` low, that step is taken on the next selected tick whatever `extDoneIn` is.
- R8: With `lockWaitEn` high, `phase` holds at `lockCycle` while any `lockIn` bit whose `lockMask` bit is 1 reads low after synchronisation. With `lockWaitEn` low, the lock inputs have no effect.
- R9: A change on `extDoneIn` or `lockIn` takes part in the advance decision from the second rising clock edge after it settles (two-flop synchroniser).
- R10: `userMode` rises together with `phase` reaching 6. It stays high until reset.
- R11: A code of 0 or 7 on `doneCycle`, `gtsCycle`, `gweCycle` or `lockCycle` behaves as phase 6.
- R12: While `rstSync` is high at a rising edge, the block returns to `phase` 0 with `doneOut` low, `gweOut` low, `userMode` low, the tri-state held, and both synchronisers cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rstSync | input | 1 | Synchronous reset, active high |
| clkSel | input | 2 | Advancing source select (0/3 config, 1 user, 2 test port) |
| cfgTick | input | 1 | Configuration-clock tick enable |
| userTick | input | 1 | User-logic clock tick enable |
| jtagTick | input | 1 | Test-access-port clock tick enable |
| doneCycle | input | 3 | Phase that raises DONE |
| gtsCycle | input | 3 | Phase that releases the global tri-state |
| gweCycle | input | 3 | Phase that grants global write enable |
| waitDoneEn | input | 1 | Hold tri-state / write-enable release for external DONE |
| lockWaitEn | input | 1 | Enable the lock wait |
| lockCycle | input | 3 | Phase at which the lock wait holds |
| lockMask | input | NUM_LOCK | Lock inputs taking part in the wait |
| extDoneIn | input | 1 | External DONE level, asynchronous |
| lockIn | input | NUM_LOCK | Clock-manager lock levels, asynchronous |
| userGsr | input | 1 | User request for global set/reset |
| userGts | input | 1 | User request for global tri-state |
| phase | output | 3 | Current start-up phase |
| doneOut | output | 1 | DONE indication |
| gtsOut | output | 1 | Global tri-state, high holds outputs off |
| gweOut | output | 1 | Global write enable |
| gsrOut | output | 1 | Global set/reset |
| userMode | output | 1 | Sticky user-mode flag |

## Verification
A wrong phase count shows up at once on `phase`. Because the three release outputs are threshold functions of that count, a skipped or repeated step also moves `doneOut`, `gtsOut` or `gweOut` in the same cycle. A synchroniser that is one stage short or long, or a stall test that reads the wrong lock bit, changes the edge where the stalled phase finally steps. The reference model compares every output one time unit after each rising edge, so such an error is reported on the first edge where the model and the design disagree.

// File: rtl/startup_pkg.sv
package startup_pkg;

  localparam int PH_W       = 3;
  localparam int LAST_PHASE = 6;

  typedef enum logic [1:0] {
    SRC_CFG     = 2'd0,
    SRC_USER    = 2'd1,
    SRC_JTAG    = 2'd2,
    SRC_CFG_ALT = 2'd3
  } clkSrc_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic doneSet;
    logic gtsRel;
    logic gweRel;
    logic finish;
  } seqStrobe_t;

  function automatic logic [PH_W-1:0] clampPhase(input logic [PH_W-1:0] code);
    if (code == '0 || code > PH_W'(LAST_PHASE)) return PH_W'(LAST_PHASE);
    return code;
  endfunction

endpackage

// File: rtl/seq_dpath.sv
module seq_dpath
  import startup_pkg::*;
#(
  parameter int NUM_LOCK = 2
)(
  input  logic                clk,
  input  logic                rstSync,
  input  logic [1:0]          clkSel,
  input  logic                cfgTick,
  input  logic                userTick,
  input  logic                jtagTick,
  input  logic                extDoneIn,
  input  logic [NUM_LOCK-1:0] lockIn,
  input  logic [NUM_LOCK-1:0] lockMask,
  input  logic                userGsr,
  input  logic                userGts,
  input  seqStrobe_t          stb,
  output logic                tick,
  output logic                doneSync,
  output logic                lockOk,
  output logic                doneOut,
  output logic                gtsOut,
  output logic                gweOut,
  output logic                gsrOut,
  output logic                userMode
);

  logic                doneMeta;
  logic [NUM_LOCK-1:0] lockMeta, lockSync;
  logic                doneQ, gtsHoldQ, gweQ, userModeQ;
  clkSrc_t             srcSel;

  assign srcSel = clkSrc_t'(clkSel);

  // enable mux: one clock domain, no gated clocks
  always_comb begin
    case (srcSel)
      SRC_USER: tick = userTick;
      SRC_JTAG: tick = jtagTick;
      default:  tick = cfgTick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstSync) begin
      doneMeta <= 1'b0;
      doneSync <= 1'b0;
      lockMeta <= '0;
      lockSync <= '0;
    end else begin
      doneMeta <= extDoneIn;
      doneSync <= doneMeta;
      lockMeta <= lockIn;
      lockSync <= lockMeta;
    end
  end

  assign lockOk = &(lockSync | ~lockMask);

  always_ff @(posedge clk) begin
    if (rstSync) begin
      doneQ     <= 1'b0;
      gtsHoldQ  <= 1'b1;
      gweQ      <= 1'b0;
      userModeQ <= 1'b0;
    end else begin
      if (stb.doneSet) doneQ     <= 1'b1;
      if (stb.gtsRel)  gtsHoldQ  <= 1'b0;
      if (stb.gweRel)  gweQ      <= 1'b1;
      if (stb.finish)  userModeQ <= 1'b1;
    end
  end

  assign doneOut  = doneQ;
  assign gweOut   = gweQ;
  assign gtsOut   = gtsHoldQ | userGts;
  assign gsrOut   = userGsr;
  assign userMode = userModeQ;

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (rstSync)
    doneQ |=> doneQ);

  // R3
  gts_release_sticky_chk: assert property (@(posedge clk) disable iff (rstSync)
    !gtsHoldQ |=> !gtsHoldQ);

  // R10
  user_mode_sticky_chk: assert property (@(posedge clk) disable iff (rstSync)
    userModeQ |=> userModeQ);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import startup_pkg::*;
(
  input  logic            clk,
  input  logic            rstSync,
  input  logic            tick,
  input  logic [PH_W-1:0] doneCycle,
  input  logic [PH_W-1:0] gtsCycle,
  input  logic [PH_W-1:0] gweCycle,
  input  logic            waitDoneEn,
  input  logic            lockWaitEn,
  input  logic [PH_W-1:0] lockCycle,
  input  logic            doneSync,
  input  logic            lockOk,
  output logic [PH_W-1:0] phase,
  output seqStrobe_t      stb
);

  logic [PH_W-1:0] phaseQ, nxtPhase;
  logic [PH_W-1:0] donePh, gtsPh, gwePh, lockPh;
  logic            atLast, doneStall, lockStall, adv;

  assign donePh   = clampPhase(doneCycle);
  assign gtsPh    = clampPhase(gtsCycle);
  assign gwePh    = clampPhase(gweCycle);
  assign lockPh   = clampPhase(lockCycle);
  assign nxtPhase = phaseQ + PH_W'(1);
  assign atLast   = (phaseQ == PH_W'(LAST_PHASE));

  assign doneStall = waitDoneEn && !doneSync &&
                     (nxtPhase == gtsPh || nxtPhase == gwePh);
  assign lockStall = lockWaitEn && !lockOk && (phaseQ == lockPh);
  assign adv       = tick && !atLast && !doneStall && !lockStall;

  always_comb begin
    stb.doneSet = adv && (nxtPhase == donePh);
    stb.gtsRel  = adv && (nxtPhase == gtsPh);
    stb.gweRel  = adv && (nxtPhase == gwePh);
    stb.finish  = adv && (nxtPhase == PH_W'(LAST_PHASE));
  end

  always_ff @(posedge clk) begin
    if (rstSync) phaseQ <= '0;
    else if (adv) phaseQ <= nxtPhase;
  end

  assign phase = phaseQ;

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rstSync)
    (phaseQ != $past(phaseQ)) |-> (phaseQ == $past(phaseQ) + PH_W'(1)));

  // R1
  phase_limit_chk: assert property (@(posedge clk) disable iff (rstSync)
    phaseQ <= PH_W'(LAST_PHASE));

  // R7
  done_wait_hold_chk: assert property (@(posedge clk) disable iff (rstSync)
    (waitDoneEn && !doneSync && (nxtPhase == gtsPh || nxtPhase == gwePh))
      |=> $stable(phaseQ));

  // R8
  lock_wait_hold_chk: assert property (@(posedge clk) disable iff (rstSync)
    (lockWaitEn && !lockOk && phaseQ == lockPh) |=> $stable(phaseQ));

endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int NUM_LOCK = 2
)(
  input  logic                clk,
  input  logic                rstSync,
  input  logic [1:0]          clkSel,
  input  logic                cfgTick,
  input  logic                userTick,
  input  logic                jtagTick,
  input  logic [PH_W-1:0]     doneCycle,
  input  logic [PH_W-1:0]     gtsCycle,
  input  logic [PH_W-1:0]     gweCycle,
  input  logic                waitDoneEn,
  input  logic                lockWaitEn,
  input  logic [PH_W-1:0]     lockCycle,
  input  logic [NUM_LOCK-1:0] lockMask,
  input  logic                extDoneIn,
  input  logic [NUM_LOCK-1:0] lockIn,
  input  logic                userGsr,
  input  logic                userGts,
  output logic [PH_W-1:0]     phase,
  output logic                doneOut,
  output logic                gtsOut,
  output logic                gweOut,
  output logic                gsrOut,
  output logic                userMode
);

  seqStrobe_t stb;
  logic       tick, doneSync, lockOk;

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rstSync   (rstSync),
    .tick      (tick),
    .doneCycle (doneCycle),
    .gtsCycle  (gtsCycle),
    .gweCycle  (gweCycle),
    .waitDoneEn(waitDoneEn),
    .lockWaitEn(lockWaitEn),
    .lockCycle (lockCycle),
    .doneSync  (doneSync),
    .lockOk    (lockOk),
    .phase     (phase),
    .stb       (stb)
  );

  seq_dpath #(.NUM_LOCK(NUM_LOCK)) u_dpath (
    .clk      (clk),
    .rstSync  (rstSync),
    .clkSel   (clkSel),
    .cfgTick  (cfgTick),
    .userTick (userTick),
    .jtagTick (jtagTick),
    .extDoneIn(extDoneIn),
    .lockIn   (lockIn),
    .lockMask (lockMask),
    .userGsr  (userGsr),
    .userGts  (userGts),
    .stb      (stb),
    .tick     (tick),
    .doneSync (doneSync),
    .lockOk   (lockOk),
    .doneOut  (doneOut),
    .gtsOut   (gtsOut),
    .gweOut   (gweOut),
    .gsrOut   (gsrOut),
    .userMode (userMode)
  );

endmodule

// File: tb/startup_seq_bench.sv
module startup_seq_bench;

  localparam int CLK_P    = 10;
  localparam int NUM_LOCK = 2;
  localparam int WATCHDOG = 20000;

  logic                clk = 1'b0;
  logic                rstSync = 1'b1;
  logic [1:0]          clkSel = 2'd0;
  logic                cfgTick = 1'b0, userTick = 1'b0, jtagTick = 1'b0;
  logic [2:0]          doneCycle = 3'd4, gtsCycle = 3'd5, gweCycle = 3'd6, lockCycle = 3'd3;
  logic                waitDoneEn = 1'b0, lockWaitEn = 1'b0;
  logic [NUM_LOCK-1:0] lockMask = '0, lockIn = '0;
  logic                extDoneIn = 1'b0, userGsr = 1'b0, userGts = 1'b0;
  logic [2:0]          phase;
  logic                doneOut, gtsOut, gweOut, gsrOut, userMode;

  int    nChecks = 0, nFails = 0, cycles = 0;
  string scen = "R12 reset";

  int                  mPhase = 0;
  logic                mD1 = 0, mD2 = 0;
  logic [NUM_LOCK-1:0] mL1 = '0, mL2 = '0;

  startup_seq #(.NUM_LOCK(NUM_LOCK)) u_startup_seq (
    .clk(clk), .rstSync(rstSync), .clkSel(clkSel),
    .cfgTick(cfgTick), .userTick(userTick), .jtagTick(jtagTick),
    .doneCycle(doneCycle), .gtsCycle(gtsCycle), .gweCycle(gweCycle),
    .waitDoneEn(waitDoneEn), .lockWaitEn(lockWaitEn), .lockCycle(lockCycle),
    .lockMask(lockMask), .extDoneIn(extDoneIn), .lockIn(lockIn),
    .userGsr(userGsr), .userGts(userGts),
    .phase(phase), .doneOut(doneOut), .gtsOut(gtsOut), .gweOut(gweOut),
    .gsrOut(gsrOut), .userMode(userMode)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int effPhase(input logic [2:0] c);
    return (c == 0 || c == 7) ? 6 : int'(c);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, scen, $time, act, exp);
    end
  endtask

  // tick generators: cfg every 2, user every 3, jtag every 5 cycles
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      cfgTick  = (n % 2 == 0);
      userTick = (n % 3 == 0);
      jtagTick = (n % 5 == 0);
    end
  end

  // behavioural reference and per-cycle comparison
  always @(posedge clk) begin
    cycles++;
    if (rstSync) begin
      mPhase = 0; mD1 = 0; mD2 = 0; mL1 = '0; mL2 = '0;
    end else begin
      logic tk, st;
      int   nx;
      tk = (clkSel == 2'd1) ? userTick : (clkSel == 2'd2) ? jtagTick : cfgTick;
      nx = mPhase + 1;
      st = 1'b0;
      if (waitDoneEn && !mD2 && (nx == effPhase(gtsCycle) || nx == effPhase(gweCycle))) st = 1'b1;
      if (lockWaitEn && mPhase == effPhase(lockCycle) && ((mL2 & lockMask) != lockMask)) st = 1'b1;
      if (tk && mPhase < 6 && !st) mPhase = nx;
      mD2 = mD1; mD1 = extDoneIn;
      mL2 = mL1; mL1 = lockIn;
    end
    #1;
    check("R1 phase",    int'(phase),    mPhase);
    check("R2 doneOut",  int'(doneOut),  int'(mPhase >= effPhase(doneCycle)));
    check("R3 gtsOut",   int'(gtsOut),   int'(mPhase < effPhase(gtsCycle) || userGts));
    check("R4 gweOut",   int'(gweOut),   int'(mPhase >= effPhase(gweCycle)));
    check("R6 gsrOut",   int'(gsrOut),   int'(userGsr));
    check("R10 userMode", int'(userMode), int'(mPhase == 6));
  end

  task automatic doReset();
    @(negedge clk); rstSync = 1'b1;
    @(negedge clk); @(negedge clk); rstSync = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R12: reset state checked explicitly
    run(3);
    check("R12 phase", int'(phase), 0);
    check("R12 gtsOut", int'(gtsOut), 1);
    check("R12 gweOut", int'(gweOut), 0);
    check("R12 doneOut", int'(doneOut), 0);

    // R7 R8 disabled waits: advance unconditionally on config clock
    scen = "R5 cfg clock, R7/R8 waits off";
    doReset();
    run(40);
    check("R10 user mode reached", int'(userMode), 1);

    // R5 user clock, release order reversed
    rstSync = 1'b1; scen = "R5 user clock";
    clkSel = 2'd1; doneCycle = 3'd6; gtsCycle = 3'd2; gweCycle = 3'd3;
    doReset();
    run(40);

    // R6 user requests after user mode
    scen = "R6 user overrides";
    userGts = 1'b1; run(3); userGsr = 1'b1; run(3);
    userGts = 1'b0; run(2); userGsr = 1'b0; run(2);

    // R7 R9 done wait on test-port clock
    rstSync = 1'b1; scen = "R7 done wait, R9 sync";
    clkSel = 2'd2; doneCycle = 3'd2; gtsCycle = 3'd4; gweCycle = 3'd5;
    waitDoneEn = 1'b1; extDoneIn = 1'b0;
    doReset();
    run(60);
    check("R7 stalled before release", int'(phase), 3);
    extDoneIn = 1'b1;
    run(40);

    // R8 R9 lock wait, masked bit stays low
    rstSync = 1'b1; scen = "R8 lock wait";
    clkSel = 2'd3; waitDoneEn = 1'b0; extDoneIn = 1'b0;
    doneCycle = 3'd1; gtsCycle = 3'd5; gweCycle = 3'd5;
    lockWaitEn = 1'b1; lockCycle = 3'd3; lockMask = 2'b10; lockIn = 2'b01;
    doReset();
    run(30);
    check("R8 held at lock phase", int'(phase), 3);
    lockIn = 2'b10;
    run(30);

    // R11 out-of-range codes behave as phase 6
    rstSync = 1'b1; scen = "R11 codes 0 and 7";
    clkSel = 2'd0; lockWaitEn = 1'b0; lockIn = '0;
    doneCycle = 3'd0; gtsCycle = 3'd7; gweCycle = 3'd0; lockCycle = 3'd7;
    doReset();
    run(8);
    check("R11 no early release", int'(gweOut), 0);
    run(20);

    // R12 reset mid-run
    scen = "R12 mid-run reset";
    doneCycle = 3'd1; gtsCycle = 3'd1; gweCycle = 3'd1;
    doReset();
    run(5);
    doReset();
    run(1);
    check("R12 phase after reset", int'(phase), 0);
    run(20);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    nChecks++; nFails++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule